// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the data half of a multi-cycle 32-bit processor core whose control comes from an outside sequencer. All storage hangs off one shared 32-bit bus. The storage is a register file of 32 general registers plus the program counter, an instruction register, two ALU operand registers, a memory address register and a word-organised memory behind a slow port. In every cycle the sequencer presents one flat control word. That word names at most one source to drive the bus and any set of destinations to capture it. A step such as "MA <= PC" is therefore one cycle with the PC selected, the register file driving the bus and the address register loading.

The sequencer gets three things back. It sees the low seven bits of the instruction register as an opcode for dispatch. It sees a flag that is high when the two operand registers hold equal values, which it uses for branch decisions. It sees a busy line that stays high while a memory access is in flight, so that a microinstruction can spin on it.

The memory model has a fixed latency. It starts an access whenever it is idle and a read or write is requested. It stays busy for the latency count and then presents read data, or commits the write, in the first cycle with busy low.

Top module: `ubus_datapath`

## Requirements
- R1: A synchronous active-high reset clears the PC, IR, A, B and MA to zero. Afterwards the opcode output is 0, the equal flag is 1 and busy is 0. Register file contents other than the PC, and memory contents, are not touched by reset.
- R2: Each load strobe (ld_ir, ld_a, ld_b, ld_ma) captures the bus value on the rising clock edge of the cycle in which it is high. A register whose strobe is low keeps its value. The register-select code picks the file entry for both reading and writing: 0 = index IR[19:15], 1 = index IR[24:20], 2 = index IR[11:7], 3 = PC, 4 = x1, 5..7 = x0. When reg_wr is high, the bus value is written into the selected entry at the clock edge.
- R3: The sources are en_reg (register file), en_imm (immediate), en_alu (ALU result) and en_mem (memory read data). At most one of them is high in a cycle, and the bus carries that source. With none high the bus reads all zeros.
- R4: Entry x0 always reads as zero, and a write to it has no effect.
- R5: The immediate select code picks a sign-extended immediate, with the sign taken from IR[31]. The codes are: 0 = {IR[31:20]}; 1 = {IR[31:25],IR[11:7]}; 2 = {IR[31],IR[7],IR[30:25],IR[11:8],0}; 3 = {IR[31:12],12 zeros}, no extension; 4 = {IR[31],IR[19:12],IR[20],IR[30:21],0}. Codes 5..7 give zero.
- R6: ALU operation codes: 0 = A+B, 1 = A-B, 2 = B, 3 = A&B, 4 = A|B, 5 = A^B, 6 = signed A<B, 7 = unsigned A<B, 8 = A<<B[4:0], 9 = logical A>>B[4:0], 10 = arithmetic A>>B[4:0], 11 = A+4, 12 = A-4. Codes 13..15 give zero.
- R7: The opcode output equals IR[6:0]. The equal flag is 1 exactly when A equals B.
- R8: A memory access starts in any cycle where the port is idle and en_mem (read) or mem_wr (write) is high. It uses the word index MA[AW+1:2], where AW = log2(MEM_WORDS). Busy is high for MEM_LATENCY cycles, counting from the request cycle. In the next cycle busy is low, the access completes, and read data is on the bus if en_mem is high.
- R9: For a write, the data is the bus value in the request cycle. It is committed to the addressed word at the completion edge, and later reads of that word return it.
- R10: After configuration, memory word i holds (i * 0x9E3779B9) XOR 0x5A5A0F0F, truncated to 32 bits.
- R11: The PC lives in the register file as select code 3. It can be written from the bus and read back on it like any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_ir | input | 1 | Capture bus into instruction register |
| ld_a | input | 1 | Capture bus into operand A |
| ld_b | input | 1 | Capture bus into operand B |
| ld_ma | input | 1 | Capture bus into memory address register |
| reg_sel | input | 3 | Register file entry select code |
| reg_wr | input | 1 | Write bus into selected register file entry |
| en_reg | input | 1 | Register file drives the bus |
| imm_sel | input | 3 | Immediate format select code |
| en_imm | input | 1 | Immediate drives the bus |
| alu_op | input | 4 | ALU operation code |
| en_alu | input | 1 | ALU result drives the bus |
| mem_wr | input | 1 | Request a memory write |
| en_mem | input | 1 | Request a memory read and drive read data onto the bus |
| opcode | output | 7 | IR[6:0] for dispatch |
| zero | output | 1 | High when A equals B |
| busy | output | 1 | Memory access in flight |
| bus_out | output | 32 | Current value of the shared bus |

## Verification
The assertions assume that the sequencer never enables two bus sources in one cycle. They also assume that it keeps every control low while reset is held, and that it does not load A and B together from a bus it is changing. The bench drives the control word only through small tasks. Each task raises a single source enable, so the one-driver rule always holds. The random part draws memory word indices, immediate formats and register fields. It does not draw raw control bits, so every draw stays a legal microinstruction.

// File: rtl/ubus_pkg.sv
package ubus_pkg;

  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    SEL_RS1  = 3'd0,
    SEL_RS2  = 3'd1,
    SEL_RD   = 3'd2,
    SEL_PC   = 3'd3,
    SEL_LINK = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    IMM_I = 3'd0,
    IMM_S = 3'd1,
    IMM_B = 3'd2,
    IMM_U = 3'd3,
    IMM_J = 3'd4
  } imm_sel_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_PASB = 4'd2,
    ALU_AND  = 4'd3,
    ALU_OR   = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SLT  = 4'd6,
    ALU_SLTU = 4'd7,
    ALU_SLL  = 4'd8,
    ALU_SRL  = 4'd9,
    ALU_SRA  = 4'd10,
    ALU_INC4 = 4'd11,
    ALU_DEC4 = 4'd12
  } alu_op_e;

  // Power-up contents of memory word i.
  function automatic logic [XLEN-1:0] mem_seed(input int unsigned i);
    logic [XLEN-1:0] prod;
    prod = XLEN'(i) * 32'h9E37_79B9;
    return prod ^ 32'h5A5A_0F0F;
  endfunction

endpackage

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          is_pc,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] gpr [NREG];
  logic [W-1:0] pc_q;

  // General registers: plain array, no reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !is_pc && idx != '0) gpr[idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                pc_q <= '0;
    else if (wr_en && is_pc) pc_q <= wr_data;
  end

  always_comb begin
    if (is_pc)            rd_data = pc_q;
    else if (idx == '0)   rd_data = '0;
    else                  rd_data = gpr[idx];
  end

endmodule

// File: rtl/ubus_immgen.sv
module ubus_immgen
  import ubus_pkg::*;
(
  input  logic [31:7]     ir,
  input  logic [2:0]      sel,
  output logic [XLEN-1:0] imm
);

  logic sgn;
  assign sgn = ir[31];

  always_comb begin
    case (sel)
      IMM_I:   imm = {{20{sgn}}, ir[31:20]};
      IMM_S:   imm = {{20{sgn}}, ir[31:25], ir[11:7]};
      IMM_B:   imm = {{19{sgn}}, sgn, ir[7], ir[30:25], ir[11:8], 1'b0};
      IMM_U:   imm = {ir[31:12], 12'b0};
      IMM_J:   imm = {{11{sgn}}, sgn, ir[19:12], ir[20], ir[30:21], 1'b0};
      default: imm = '0;
    endcase
  end

endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
  import ubus_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [SW-1:0] shamt;
  assign shamt = b[SW-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_PASB: y = b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_SLT:  y = W'($signed(a) < $signed(b));
      ALU_SLTU: y = W'(a < b);
      ALU_SLL:  y = a << shamt;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = W'($signed(a) >>> shamt);
      ALU_INC4: y = a + W'(4);
      ALU_DEC4: y = a - W'(4);
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/ubus_mem.sv
module ubus_mem
  import ubus_pkg::*;
#(
  parameter int unsigned WORDS   = 64,
  parameter int unsigned LATENCY = 4,
  localparam int unsigned AW     = $clog2(WORDS),
  localparam int unsigned CW     = $clog2(LATENCY + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_rd,
  input  logic            req_wr,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic            busy,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] mem [WORDS];
  logic            active;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic            wr_q;
  logic [XLEN-1:0] wdata_q;
  logic [XLEN-1:0] rdata_q;
  logic            start, done;
  logic [AW-1:0]   rd_idx;

  initial begin
    for (int i = 0; i < int'(WORDS); i++) mem[i] = mem_seed(i);
  end

  assign start  = !active && (req_rd || req_wr);
  assign done   = active && (cnt == CW'(LATENCY));
  assign busy   = active ? !done : (req_rd || req_wr);
  assign rd_idx = start ? addr : addr_q;
  assign rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= CW'(1);
      addr_q  <= addr;
      wr_q    <= req_wr;
      wdata_q <= wdata;
    end else if (done) begin
      active  <= 1'b0;
    end else if (active) begin
      cnt     <= cnt + CW'(1);
    end
  end

  // Registered read and single write port keep the array block-RAM shaped.
  always_ff @(posedge clk) begin
    rdata_q <= mem[rd_idx];
    if (done && wr_q) mem[addr_q] <= wdata_q;
  end

endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
  import ubus_pkg::*;
#(
  parameter int unsigned MEM_WORDS   = 64,
  parameter int unsigned MEM_LATENCY = 4,
  localparam int unsigned AW         = $clog2(MEM_WORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_ir,
  input  logic        ld_a,
  input  logic        ld_b,
  input  logic        ld_ma,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        en_reg,
  input  logic [2:0]  imm_sel,
  input  logic        en_imm,
  input  logic [3:0]  alu_op,
  input  logic        en_alu,
  input  logic        mem_wr,
  input  logic        en_mem,
  output logic [6:0]  opcode,
  output logic        zero,
  output logic        busy,
  output logic [31:0] bus_out
);

  logic [XLEN-1:0] ir_q, a_q, b_q, ma_q;
  logic [XLEN-1:0] bus;
  logic [XLEN-1:0] rf_data, imm_data, alu_data, mem_data;
  logic [4:0]      rf_idx;
  logic            rf_is_pc;
  logic            unused_ma_bits;

  always_comb begin
    case (reg_sel)
      SEL_RS1:  rf_idx = ir_q[19:15];
      SEL_RS2:  rf_idx = ir_q[24:20];
      SEL_RD:   rf_idx = ir_q[11:7];
      SEL_LINK: rf_idx = 5'd1;
      default:  rf_idx = 5'd0;
    endcase
  end
  assign rf_is_pc = (reg_sel == SEL_PC);

  ubus_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .idx     (rf_idx),
    .is_pc   (rf_is_pc),
    .wr_en   (reg_wr),
    .wr_data (bus),
    .rd_data (rf_data)
  );

  ubus_immgen u_imm (
    .ir  (ir_q[31:7]),
    .sel (imm_sel),
    .imm (imm_data)
  );

  ubus_alu #(.W(XLEN)) u_alu (
    .op (alu_op),
    .a  (a_q),
    .b  (b_q),
    .y  (alu_data)
  );

  ubus_mem #(.WORDS(MEM_WORDS), .LATENCY(MEM_LATENCY)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .req_rd (en_mem),
    .req_wr (mem_wr),
    .addr   (ma_q[AW+1:2]),
    .wdata  (bus),
    .busy   (busy),
    .rdata  (mem_data)
  );

  assign unused_ma_bits = ^{ma_q[XLEN-1:AW+2], ma_q[1:0]};

  // AND-OR bus: each driver gated by its enable, all-zero when idle.
  assign bus = ({XLEN{en_reg}} & rf_data)
             | ({XLEN{en_imm}} & imm_data)
             | ({XLEN{en_alu}} & alu_data)
             | ({XLEN{en_mem}} & mem_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  assign opcode  = ir_q[6:0];
  assign zero    = (a_q == b_q);
  assign bus_out = bus;

endmodule

// File: rtl/ubus_datapath_chk.sv
module ubus_datapath_chk #(
  parameter int unsigned LATENCY = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        en_reg,
  input logic        en_imm,
  input logic        en_alu,
  input logic        en_mem,
  input logic        mem_wr,
  input logic        ld_a,
  input logic        ld_b,
  input logic        ld_ir,
  input logic [31:0] bus_out,
  input logic        busy,
  input logic        zero,
  input logic [6:0]  opcode,
  input logic [31:0] a_q
);

  assert_single_driver_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({en_reg, en_imm, en_alu, en_mem}) <= 1);

  assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !(en_reg || en_imm || en_alu || en_mem) |-> (bus_out == 32'd0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> (a_q == $past(bus_out)));

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_ir |=> $stable(opcode));

  assert_equal_loads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_a && ld_b) |=> zero);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (opcode == 7'd0 && zero));

  assert_busy_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (en_mem || mem_wr));

  generate
    if (LATENCY >= 2) begin : g_multi
      assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
    end
  endgenerate

endmodule

bind ubus_datapath ubus_datapath_chk #(.LATENCY(MEM_LATENCY)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_reg  (en_reg),
  .en_imm  (en_imm),
  .en_alu  (en_alu),
  .en_mem  (en_mem),
  .mem_wr  (mem_wr),
  .ld_a    (ld_a),
  .ld_b    (ld_b),
  .ld_ir   (ld_ir),
  .bus_out (bus_out),
  .busy    (busy),
  .zero    (zero),
  .opcode  (opcode),
  .a_q     (a_q)
);

// File: tb/ubus_datapath_tb.sv
`timescale 1ns/1ps
module ubus_datapath_tb;

  localparam int WORDS = 64;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_ir, ld_a, ld_b, ld_ma, reg_wr, en_reg, en_imm, en_alu, mem_wr, en_mem;
  logic [2:0]  reg_sel, imm_sel;
  logic [3:0]  alu_op;
  logic [6:0]  opcode;
  logic        zero, busy;
  logic [31:0] bus_out;

  int checks = 0;
  int failures = 0;

  logic [31:0] mdl [WORDS];
  logic [31:0] regs [32];
  bit          known [32];
  logic [31:0] e_ir, e_a, e_b, e_ma, e_pc;

  always #5 clk = ~clk;

  ubus_datapath #(.MEM_WORDS(WORDS), .MEM_LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .en_reg(en_reg), .imm_sel(imm_sel),
    .en_imm(en_imm), .alu_op(alu_op), .en_alu(en_alu), .mem_wr(mem_wr),
    .en_mem(en_mem), .opcode(opcode), .zero(zero), .busy(busy), .bus_out(bus_out)
  );

  function automatic logic [31:0] f_seed(int i);
    logic [31:0] p;
    p = 32'(i) * 32'h9E37_79B9;
    return p ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] f_imm(logic [31:0] ir, int s);
    case (s)
      0: return {{20{ir[31]}}, ir[31:20]};
      1: return {{20{ir[31]}}, ir[31:25], ir[11:7]};
      2: return {{20{ir[31]}}, ir[7], ir[30:25], ir[11:8], 1'b0};
      3: return {ir[31:12], 12'h000};
      4: return {{12{ir[31]}}, ir[19:12], ir[20], ir[30:21], 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] f_alu(int op, logic [31:0] a, logic [31:0] b);
    int sh;
    sh = int'(b[4:0]);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return b;
      3:  return a & b;
      4:  return a | b;
      5:  return a ^ b;
      6:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      7:  return (a < b) ? 32'd1 : 32'd0;
      8:  return a << sh;
      9:  return a >> sh;
      10: return $unsigned($signed(a) >>> sh);
      11: return a + 32'd4;
      12: return a - 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int f_idx(int sel, logic [31:0] ir);
    case (sel)
      0: return int'(ir[19:15]);
      1: return int'(ir[24:20]);
      2: return int'(ir[11:7]);
      4: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    {ld_ir, ld_a, ld_b, ld_ma, reg_wr, en_reg, en_imm, en_alu, mem_wr, en_mem} = '0;
    reg_sel = 3'd0; imm_sel = 3'd0; alu_op = 4'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic peek_reg(input int sel, output logic [31:0] v);
    clr(); en_reg = 1'b1; reg_sel = 3'(sel);
    #1 v = bus_out;
    @(negedge clk); clr();
  endtask

  task automatic peek_alu(input int op, output logic [31:0] v);
    clr(); en_alu = 1'b1; alu_op = 4'(op);
    #1 v = bus_out;
    @(negedge clk); clr();
  endtask

  task automatic peek_imm(input int s, output logic [31:0] v);
    clr(); en_imm = 1'b1; imm_sel = 3'(s);
    #1 v = bus_out;
    @(negedge clk); clr();
  endtask

  // Request raised by caller-set strobes; spin until busy drops.
  task automatic mem_op(input bit wr, output int nbusy);
    if (wr) mem_wr = 1'b1; else en_mem = 1'b1;
    nbusy = 0;
    forever begin
      #1;
      if (busy) begin
        nbusy++;
        @(negedge clk);
      end else begin
        @(negedge clk);
        break;
      end
    end
    clr();
  endtask

  task automatic reg_write(input int sel, input logic [31:0] v);
    int i;
    if (sel == 3) e_pc = v;
    else begin
      i = f_idx(sel, e_ir);
      if (i != 0) begin regs[i] = v; known[i] = 1'b1; end
    end
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nb, s, wi;
    void'($urandom(32'd20250611));
    for (int i = 0; i < WORDS; i++) mdl[i] = f_seed(i);
    for (int i = 0; i < 32; i++) known[i] = 1'b0;
    rst = 1'b1; clr();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_ir = 0; e_a = 0; e_b = 0; e_ma = 0; e_pc = 0;

    // R1 reset state
    peek_reg(3, v);   check("R1 pc after reset", v, 32'd0);
    check("R1 opcode after reset", {25'd0, opcode}, 32'd0);
    check("R1 zero after reset", {31'd0, zero}, 32'd1);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    peek_alu(0, v);   check("R1 A+B after reset", v, 32'd0);
    #1 check("R3 idle bus", bus_out, 32'd0);
    peek_reg(5, v);   check("R4 x0 via code 5", v, 32'd0);

    // x1 <= 0 from an idle bus
    clr(); reg_sel = 3'd4; reg_wr = 1'b1; tick(); reg_write(4, 32'd0);

    for (int k = 0; k < 12; k++) begin
      wi = int'(e_ma[7:2]);
      // IR and A from memory (R8, R10)
      ld_ir = 1'b1; ld_a = 1'b1;
      mem_op(1'b0, nb);
      check("R8 busy cycles read", 32'(nb), 32'(LAT));
      #1 check("R8 busy low after done", {31'd0, busy}, 32'd0);
      e_ir = mdl[wi]; e_a = mdl[wi];
      check("R7 R10 opcode from word", {25'd0, opcode}, {25'd0, e_ir[6:0]});
      for (int t = 0; t < 8; t++) begin
        peek_imm(t, v); check("R5 immediate", v, f_imm(e_ir, t));
      end
      // B from a random immediate
      s = $urandom_range(0, 4);
      clr(); en_imm = 1'b1; imm_sel = 3'(s); ld_b = 1'b1; tick();
      e_b = f_imm(e_ir, s);
      check("R7 zero flag", {31'd0, zero}, {31'd0, e_a == e_b});
      for (int op = 0; op < 16; op++) begin
        peek_alu(op, v); check("R6 alu result", v, f_alu(op, e_a, e_b));
      end
      // Register file through IR fields (R2, R4)
      clr(); en_alu = 1'b1; alu_op = 4'd5; reg_sel = 3'd2; reg_wr = 1'b1; tick();
      reg_write(2, e_a ^ e_b);
      peek_reg(2, v);
      check("R2 R4 rd readback", v, (e_ir[11:7] == 0) ? 32'd0 : (e_a ^ e_b));
      for (int sl = 0; sl < 2; sl++) begin
        if (f_idx(sl, e_ir) == 0) begin
          peek_reg(sl, v); check("R4 x0 through field", v, 32'd0);
        end else if (known[f_idx(sl, e_ir)]) begin
          peek_reg(sl, v); check("R2 source field read", v, regs[f_idx(sl, e_ir)]);
        end
      end
      // advance: A <= x1 ; x1 <= A+4 ; MA <= x1
      clr(); en_reg = 1'b1; reg_sel = 3'd4; ld_a = 1'b1; tick(); e_a = regs[1];
      clr(); en_alu = 1'b1; alu_op = 4'd11; reg_sel = 3'd4; reg_wr = 1'b1; tick();
      reg_write(4, e_a + 32'd4);
      clr(); en_reg = 1'b1; reg_sel = 3'd4; ld_ma = 1'b1; tick(); e_ma = regs[1];
    end

    // R11 PC written from ALU and read back
    clr(); en_reg = 1'b1; reg_sel = 3'd4; ld_a = 1'b1; tick(); e_a = regs[1];
    clr(); en_alu = 1'b1; alu_op = 4'd11; reg_sel = 3'd3; reg_wr = 1'b1; tick();
    e_pc = e_a + 32'd4;
    peek_reg(3, v); check("R11 pc readback", v, e_pc);

    // R9 write PC into M[MA], read back into B
    wi = int'(e_ma[7:2]);
    en_reg = 1'b1; reg_sel = 3'd3;
    mem_op(1'b1, nb);
    check("R8 busy cycles write", 32'(nb), 32'(LAT));
    mdl[wi] = e_pc;
    ld_b = 1'b1;
    mem_op(1'b0, nb);
    e_b = mdl[wi];
    peek_alu(2, v); check("R9 write then read", v, e_pc);

    // R4 write to x0 through code 5 is dropped
    clr(); en_imm = 1'b1; imm_sel = 3'd3; reg_sel = 3'd5; reg_wr = 1'b1; tick();
    peek_reg(5, v); check("R4 x0 write ignored", v, 32'd0);

    // R7 equal operands; R2 A holds when not loaded
    clr(); en_reg = 1'b1; reg_sel = 3'd3; ld_a = 1'b1; ld_b = 1'b1; tick();
    check("R7 zero on equal", {31'd0, zero}, 32'd1);
    clr(); en_imm = 1'b1; imm_sel = 3'd0; ld_b = 1'b1; tick();
    e_b = f_imm(e_ir, 0);
    peek_alu(0, v); check("R2 A held while B loads", v, e_pc + e_b);
    #1 check("R3 idle bus again", bus_out, 32'd0);

    // R1 reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    peek_reg(3, v); check("R1 pc cleared again", v, 32'd0);
    check("R1 opcode cleared again", {25'd0, opcode}, 32'd0);
    check("R1 zero after second reset", {31'd0, zero}, 32'd1);
    ld_ir = 1'b1;
    mem_op(1'b0, nb);
    check("R1 MA cleared reads word 0", {25'd0, opcode}, {25'd0, mdl[0][6:0]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule